// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block is a parameterised row of scan cells that sits between a device's core logic and its pins. There are `N_IN` cells between the input pins and the core, and `M_OUT` cells between the core and the output pins. All cells belong to one serial chain that is clocked by a test clock. A test controller drives three strobes into the block: capture, shift and update. On a capture, the block takes a snapshot of the pin-side inputs and the core-side outputs. On a shift, it moves bits serially from `tdi` to `tdo`. On an update, it copies the chain contents into a second rank of hold latches.

Each cell has two ranks. The first is a capture/shift stage that changes on the rising test-clock edge. The second is an update rank that loads on the falling edge. Because of this split, the pins hold steady while new data is shifted in. A test-mode input selects, per cell, whether the core and the pins see their functional values or the update-rank values. With it, a board tester can drive the output pins and the core inputs, and read back what arrives at the device boundary.

Top module: `bscan_chain`

## Requirements
- R1: The chain is `N_IN+M_OUT` cells long. `tdi` feeds input cell 0. Input cell `i` feeds input cell `i+1`. The last input cell feeds output cell 0. The last output cell is the one presented at `tdo`. Chain position `i` is `pinIn[i]`'s cell, and position `N_IN+j` is `coreOut[j]`'s cell.
- R2: On a rising `tck` with `captureEn` high, input cell `i` loads `pinIn[i]`.
- R3: On a rising `tck` with `captureEn` high, output cell `j` loads `coreOut[j]`.
- R4: On a rising `tck` with `shiftEn` high and `captureEn` low, cell 0 loads `tdi` and every other cell loads its predecessor.
- R5: On a falling `tck` while shifting, `tdo` takes the value of the last cell. `tdo` is 0 whenever shifting is not in effect, that is, when `shiftEn` is low or `captureEn` is high.
- R6: On a falling `tck` with `updateEn` high, the update rank copies the capture/shift rank. Otherwise the update rank holds its value, so shifting does not disturb it.
- R7: With `testMode` low, `coreIn` equals `pinIn` and `pinOut` equals `coreOut`. With `testMode` high, `coreIn[i]` is update-rank position `i` and `pinOut[j]` is update-rank position `N_IN+j`.
- R8: `trstN` low clears the update rank to 0 at once. It leaves the capture/shift rank unchanged.
- R9: When `captureEn` and `shiftEn` are both high, the capture takes place and no shift occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Active-low test reset, update rank only |
| tdi | input | 1 | Serial test data into the chain |
| captureEn | input | 1 | Parallel-load strobe |
| shiftEn | input | 1 | Serial-shift strobe |
| updateEn | input | 1 | Update-rank load strobe |
| testMode | input | 1 | 1 selects update-rank values at the core and the pins |
| pinIn | input | N_IN | Values arriving on the device input pins |
| coreOut | input | M_OUT | Values the core drives toward the output pins |
| coreIn | output | N_IN | Values presented to the core |
| pinOut | output | M_OUT | Values driven onto the device output pins |
| tdo | output | 1 | Serial test data out of the chain |

## Verification
The assertions assume that the strobes change only between edges, away from both clock edges, so each strobe is stable for a whole rising-to-falling window. They also assume that no shift starts before the chain holds known data. The bench drives every input 2 ns after a rising edge. It always performs a capture before its first shift, and it samples the outputs 5 ns after a falling edge. The reset-clear check relies on the clear being asynchronous, and the bench pulses `trstN` between edges to exercise this.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } scanCtl_t;
endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic     captureEn,
  input  logic     shiftEn,
  input  logic     updateEn,
  output scanCtl_t ctl
);
  // Capture wins over shift (R9); update is independent of both.
  always_comb begin
    ctl.capture = captureEn;
    ctl.shift   = shiftEn && !captureEn;
    ctl.update  = updateEn;
  end
endmodule

// File: rtl/bscan_path.sv
module bscan_path
  import bscan_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int M_OUT = 4
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tdi,
  input  scanCtl_t         ctl,
  input  logic             testMode,
  input  logic [N_IN-1:0]  pinIn,
  input  logic [M_OUT-1:0] coreOut,
  output logic [N_IN-1:0]  coreIn,
  output logic [M_OUT-1:0] pinOut,
  output logic             tdo
);
  localparam int CHAIN = N_IN + M_OUT;

  logic [CHAIN-1:0] capQ;
  logic [CHAIN-1:0] updQ;
  logic [CHAIN-1:0] captureVec;
  logic             tdoQ;

  // Input cells sit at the low positions, output cells above them (R1).
  assign captureVec = {coreOut, pinIn};

  // Capture/shift rank: rising edge, no reset (R2, R3, R4, R8).
  always_ff @(posedge tck) begin
    if (ctl.capture)
      capQ <= captureVec;
    else if (ctl.shift)
      capQ <= {capQ[CHAIN-2:0], tdi};
  end

  // Update rank: falling edge, async clear (R6, R8).
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)
      updQ <= '0;
    else if (ctl.update)
      updQ <= capQ;
  end

  // Serial output retimed to the falling edge (R5).
  always_ff @(negedge tck) begin
    tdoQ <= ctl.shift ? capQ[CHAIN-1] : 1'b0;
  end
  assign tdo = ctl.shift ? tdoQ : 1'b0;

  // Per-cell parallel output multiplexers (R7).
  for (genvar gi = 0; gi < N_IN; gi++) begin : gInCell
    assign coreIn[gi] = testMode ? updQ[gi] : pinIn[gi];
  end
  for (genvar gj = 0; gj < M_OUT; gj++) begin : gOutCell
    assign pinOut[gj] = testMode ? updQ[N_IN+gj] : coreOut[gj];
  end

  a_r2_capture_pins: assert property (@(posedge tck) disable iff (!trstN)
    ctl.capture |=> capQ[N_IN-1:0] == $past(pinIn));

  a_r3_capture_core: assert property (@(posedge tck) disable iff (!trstN)
    ctl.capture |=> capQ[CHAIN-1:N_IN] == $past(coreOut));

  a_r4_shift_entry: assert property (@(posedge tck) disable iff (!trstN)
    ctl.shift |=> capQ[0] == $past(tdi));

  a_r4_shift_move: assert property (@(posedge tck) disable iff (!trstN)
    ctl.shift |=> capQ[CHAIN-1:1] == $past(capQ[CHAIN-2:0]));

  a_r6_update_hold: assert property (@(negedge tck) disable iff (!trstN)
    !ctl.update |=> $stable(updQ));

  a_r8_reset_clear: assert property (@(negedge tck)
    !trstN |-> updQ == '0);
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int M_OUT = 4
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tdi,
  input  logic             captureEn,
  input  logic             shiftEn,
  input  logic             updateEn,
  input  logic             testMode,
  input  logic [N_IN-1:0]  pinIn,
  input  logic [M_OUT-1:0] coreOut,
  output logic [N_IN-1:0]  coreIn,
  output logic [M_OUT-1:0] pinOut,
  output logic             tdo
);
  scanCtl_t ctl;

  bscan_ctrl uCtrl (
    .captureEn (captureEn),
    .shiftEn   (shiftEn),
    .updateEn  (updateEn),
    .ctl       (ctl)
  );

  bscan_path #(.N_IN(N_IN), .M_OUT(M_OUT)) uPath (
    .tck      (tck),
    .trstN    (trstN),
    .tdi      (tdi),
    .ctl      (ctl),
    .testMode (testMode),
    .pinIn    (pinIn),
    .coreOut  (coreOut),
    .coreIn   (coreIn),
    .pinOut   (pinOut),
    .tdo      (tdo)
  );

  a_r9_capture_wins: assert property (@(posedge tck) disable iff (!trstN)
    captureEn |-> tdo == 1'b0);
endmodule

// File: tb/tb_bscan_chain.sv
module tb_bscan_chain;
  localparam int NI = 4;
  localparam int MO = 4;
  localparam int CH = NI + MO;

  logic          tck = 1'b0;
  logic          trstN = 1'b0;
  logic          tdi = 1'b0;
  logic          captureEn = 1'b0;
  logic          shiftEn = 1'b0;
  logic          updateEn = 1'b0;
  logic          testMode = 1'b0;
  logic [NI-1:0] pinIn = '0;
  logic [MO-1:0] coreOut = '0;
  logic [NI-1:0] coreIn;
  logic [MO-1:0] pinOut;
  logic          tdo;

  int checks = 0;
  int fails  = 0;
  logic [CH-1:0] got;

  always #10 tck = ~tck;

  bscan_chain #(.N_IN(NI), .M_OUT(MO)) dut (
    .tck(tck), .trstN(trstN), .tdi(tdi), .captureEn(captureEn),
    .shiftEn(shiftEn), .updateEn(updateEn), .testMode(testMode),
    .pinIn(pinIn), .coreOut(coreOut), .coreIn(coreIn),
    .pinOut(pinOut), .tdo(tdo)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doCapture(input logic [NI-1:0] pi, input logic [MO-1:0] co);
    @(posedge tck); #2;
    pinIn = pi; coreOut = co; captureEn = 1'b1;
    @(posedge tck); #2;
    captureEn = 1'b0;
  endtask

  // Shifts newVal in (it ends at the same positions) and returns the old chain.
  task automatic doShift(input logic [CH-1:0] newVal, output logic [CH-1:0] oldVal);
    @(posedge tck); #2;
    shiftEn = 1'b1; tdi = newVal[CH-1];
    for (int k = 0; k < CH; k++) begin
      @(negedge tck); #5;
      oldVal[CH-1-k] = tdo;
      @(posedge tck); #2;
      if (k < CH-1) tdi = newVal[CH-2-k];
    end
    shiftEn = 1'b0; tdi = 1'b0;
  endtask

  task automatic doUpdate();
    @(posedge tck); #2;
    updateEn = 1'b1;
    @(posedge tck); #2;
    updateEn = 1'b0;
  endtask

  task automatic testReset();
    pinIn = 4'hA; coreOut = 4'h5; testMode = 1'b1;
    repeat (3) @(posedge tck);
    #2;
    check("R8 coreIn cleared", 32'(coreIn), 32'h0);
    check("R8 pinOut cleared", 32'(pinOut), 32'h0);
    testMode = 1'b0; #1;
    check("R7 functional coreIn", 32'(coreIn), 32'hA);
    check("R7 functional pinOut", 32'(pinOut), 32'h5);
    trstN = 1'b1;
  endtask

  task automatic testCapture(input logic [NI-1:0] pi, input logic [MO-1:0] co);
    logic [CH-1:0] old;
    doCapture(pi, co);
    doShift('0, old);
    check("R2 input cells captured", 32'(old[NI-1:0]), 32'(pi));
    check("R3 output cells captured", 32'(old[CH-1:NI]), 32'(co));
    check("R1 chain order", 32'(old), 32'({co, pi}));
    #1;
    check("R5 tdo idle", 32'(tdo), 32'h0);
  endtask

  task automatic testUpdate();
    logic [CH-1:0] old;
    testMode = 1'b1;
    doShift(8'h96, old);
    check("R6 no update during shift", 32'(pinOut), 32'h0);
    doUpdate();
    #1;
    check("R7 pinOut test value", 32'(pinOut), 32'h9);
    check("R7 coreIn test value", 32'(coreIn), 32'h6);
    doShift(8'h3C, old);
    check("R4 shifted pattern held", 32'(old), 32'h96);
    check("R6 update rank held", 32'(pinOut), 32'h9);
    testMode = 1'b0; #1;
    check("R7 back to functional", 32'(pinOut), 32'(coreOut));
  endtask

  task automatic testPriority();
    logic [CH-1:0] old;
    @(posedge tck); #2;
    pinIn = 4'h7; coreOut = 4'hE; tdi = 1'b1;
    captureEn = 1'b1; shiftEn = 1'b1;
    @(negedge tck); #5;
    check("R9 tdo zero under capture", 32'(tdo), 32'h0);
    @(posedge tck); #2;
    captureEn = 1'b0; shiftEn = 1'b0; tdi = 1'b0;
    doShift('0, old);
    check("R9 capture won over shift", 32'(old), 32'hE7);
  endtask

  task automatic testResetKeeps();
    logic [CH-1:0] old;
    doShift(8'hA5, old);
    doUpdate();
    testMode = 1'b1; #1;
    check("R7 pinOut before reset", 32'(pinOut), 32'hA);
    @(posedge tck); #2;
    trstN = 1'b0;
    #3;
    check("R8 async clear pinOut", 32'(pinOut), 32'h0);
    check("R8 async clear coreIn", 32'(coreIn), 32'h0);
    @(posedge tck); #2;
    trstN = 1'b1;
    doShift('0, old);
    check("R8 chain kept through reset", 32'(old), 32'hA5);
    testMode = 1'b0;
  endtask

  initial begin
    testReset();
    testCapture(4'hA, 4'h5);
    testCapture(4'h3, 4'hC);
    testUpdate();
    testPriority();
    testResetKeeps();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule